// File: doc/BRIEF.md
# Legacy Configuration Port with Key Lock and Device Banking

This block answers two byte-wide addresses on a legacy I/O bus. The lower address is an index (pointer) port and the upper one is a data port. After reset the port is locked: it decodes its two addresses but hides every register. Software opens it by writing an enter key to the index port twice in a row. It closes the port again by writing an exit key to the same port.

While the port is open, an index write selects one of 256 configuration registers, and data-port reads and writes then reach that register. Indices below 0x30 are global. Among them are a logical-device-number register and a read-only identification byte. Indices 0x30 and above are banked by the device number. Only one device, the watchdog bank, exists in this block. Its accesses are forwarded to an external register file as single-cycle strobes. Every other bank reads as 0xFF.

The host bus uses plain single-cycle strobes and carries no flow control. Every access completes in the cycle it is presented. Read data is combinational in that same cycle, and the forwarded read takes its byte from the register file within that cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at BASE and the data port at BASE+1, with BASE = 0x2E when `strap_alt`=0 and 0x4E when `strap_alt`=1. `io_hit` is high exactly when `io_addr` equals one of these two addresses.
- R2: The port opens one cycle after the second of two back-to-back index-port writes of 0x87. Any other index-port write in between restarts the matching. Data-port accesses do not disturb it.
- R3: While open, an index-port write of 0xAA locks the port one cycle later. The full two-write key is then needed again.
- R4: While open, an index-port write of any value other than 0xAA loads the pointer. A read of the index port returns the pointer.
- R5: Index 0x20 reads as the CHIP_ID parameter (default 0x52), and data writes to it have no effect.
- R6: Index 0x07 is the read/write logical device number. Every other global index (below 0x30) reads 0xFF and ignores writes.
- R7: With pointer >= 0x30 and device number equal to DEV_LDN (default 0x08), a data write pulses `rf_wr` in that cycle with `rf_addr` = pointer and `rf_wdata` = the written byte. A data read pulses `rf_rd` and returns `rf_rdata` in that cycle.
- R8: With pointer >= 0x30 and any other device number, data reads return 0xFF and neither `rf_wr` nor `rf_rd` pulses.
- R9: While locked, reads of both ports return 0xFF. Data writes change nothing, including the device number, and neither strobe pulses.
- R10: After reset the port is locked, the pointer is 0x00 and the device number is 0x00.
- R11: `io_rdata` is 0xFF in every cycle without a read of one of the two port addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when nothing answers |
| io_hit | output | 1 | Address decodes to this port |
| rf_wr | output | 1 | Watchdog bank write strobe |
| rf_rd | output | 1 | Watchdog bank read strobe |
| rf_addr | output | 8 | Register index for the watchdog bank |
| rf_wdata | output | 8 | Write data for the watchdog bank |
| rf_rdata | input | 8 | Read data from the watchdog bank |

## Verification
The hardest state to reach is a watchdog-bank access. It needs the full key, an index write of 0x07, a data write of the device number, and then an index write of 0x30 or above. A single wrong step leaves the strobes silent, and they are silent anyway. The stimulus walks that exact path. It first reaches the same upper indices with a different device number to show that the strobes stay low. It then interleaves data-port writes and wrong index bytes with the key, and changes the base strap mid-run. A behavioural model follows every cycle.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;
  localparam byte_t BUS_IDLE = 8'hFF;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
#(
  parameter byte_t KEY_ENTER = 8'h87,
  parameter byte_t KEY_EXIT  = 8'hAA
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_wr,
  input  byte_t wdata,
  output logic  cfg_open
);
  lock_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      unique case (st_q)
        LK_SHUT: st_d = (wdata == KEY_ENTER) ? LK_HALF : LK_SHUT;
        LK_HALF: st_d = (wdata == KEY_ENTER) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st_d = (wdata == KEY_EXIT)  ? LK_SHUT : LK_OPEN;
        default: st_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign cfg_open = (st_q == LK_OPEN);
endmodule

// File: rtl/sio_index_regs.sv
module sio_index_regs
  import sio_cfg_pkg::*;
#(
  parameter byte_t KEY_EXIT = 8'hAA,
  parameter byte_t LDN_IDX  = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_open,
  input  logic  idx_wr,
  input  logic  dat_wr,
  input  byte_t wdata,
  output byte_t idx_q,
  output byte_t ldn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else if (cfg_open) begin
      if (idx_wr && wdata != KEY_EXIT) idx_q <= wdata;
      if (dat_wr && idx_q == LDN_IDX)  ldn_q <= wdata;
    end
  end
endmodule

// File: rtl/sio_access_route.sv
module sio_access_route
  import sio_cfg_pkg::*;
#(
  parameter byte_t CHIP_ID    = 8'h52,
  parameter byte_t DEV_LDN    = 8'h08,
  parameter byte_t LDN_IDX    = 8'h07,
  parameter byte_t ID_IDX     = 8'h20,
  parameter byte_t BANK_START = 8'h30
) (
  input  logic  cfg_open,
  input  byte_t idx_q,
  input  byte_t ldn_q,
  input  logic  idx_rd,
  input  logic  dat_rd,
  input  logic  dat_wr,
  input  byte_t wdata,
  input  byte_t rf_rdata,
  output byte_t io_rdata,
  output logic  rf_wr,
  output logic  rf_rd,
  output byte_t rf_addr,
  output byte_t rf_wdata
);
  logic banked, bank_sel;

  assign banked   = (idx_q >= BANK_START);
  assign bank_sel = banked && (ldn_q == DEV_LDN);
  assign rf_addr  = idx_q;
  assign rf_wdata = wdata;

  always_comb begin
    io_rdata = BUS_IDLE;
    rf_wr    = 1'b0;
    rf_rd    = 1'b0;
    if (cfg_open) begin
      rf_wr = dat_wr && bank_sel;
      rf_rd = dat_rd && bank_sel;
      if (idx_rd) begin
        io_rdata = idx_q;
      end else if (dat_rd) begin
        if (bank_sel)              io_rdata = rf_rdata;
        else if (banked)           io_rdata = BUS_IDLE;
        else if (idx_q == LDN_IDX) io_rdata = ldn_q;
        else if (idx_q == ID_IDX)  io_rdata = CHIP_ID;
        else                       io_rdata = BUS_IDLE;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int    ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E,
  parameter byte_t CHIP_ID    = 8'h52,
  parameter byte_t DEV_LDN    = 8'h08,
  parameter byte_t KEY_ENTER  = 8'h87,
  parameter byte_t KEY_EXIT   = 8'hAA,
  parameter byte_t LDN_IDX    = 8'h07,
  parameter byte_t ID_IDX     = 8'h20,
  parameter byte_t BANK_START = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  output logic              rf_wr,
  output logic              rf_rd,
  output logic [7:0]        rf_addr,
  output logic [7:0]        rf_wdata,
  input  logic [7:0]        rf_rdata
);
  logic [ADDR_W-1:0] base_sel;
  logic at_idx, at_dat;
  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic cfg_open;
  byte_t idx_q, ldn_q;

  assign base_sel = strap_alt ? BASE_ALT : BASE_PRI;
  assign at_idx   = (io_addr == base_sel);
  assign at_dat   = (io_addr == base_sel + ADDR_W'(1));
  assign io_hit   = at_idx || at_dat;
  assign idx_wr   = at_idx && io_wr;
  assign idx_rd   = at_idx && io_rd;
  assign dat_wr   = at_dat && io_wr;
  assign dat_rd   = at_dat && io_rd;

  sio_unlock_fsm #(
    .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT)
  ) lock_i (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .cfg_open(cfg_open)
  );

  sio_index_regs #(
    .KEY_EXIT(KEY_EXIT), .LDN_IDX(LDN_IDX)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(io_wdata), .idx_q(idx_q), .ldn_q(ldn_q)
  );

  sio_access_route #(
    .CHIP_ID(CHIP_ID), .DEV_LDN(DEV_LDN), .LDN_IDX(LDN_IDX),
    .ID_IDX(ID_IDX), .BANK_START(BANK_START)
  ) route_i (
    .cfg_open(cfg_open), .idx_q(idx_q), .ldn_q(ldn_q),
    .idx_rd(idx_rd), .dat_rd(dat_rd), .dat_wr(dat_wr), .wdata(io_wdata),
    .rf_rdata(rf_rdata), .io_rdata(io_rdata), .rf_wr(rf_wr), .rf_rd(rf_rd),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata)
  );
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E,
  parameter logic [7:0] CHIP_ID   = 8'h52,
  parameter logic [7:0] KEY_ENTER = 8'h87,
  parameter logic [7:0] KEY_EXIT  = 8'hAA,
  parameter logic [7:0] ID_IDX    = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_alt,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              rf_wr,
  input logic              rf_rd,
  input logic              cfg_open,
  input logic [7:0]        idx_q
);
  logic [ADDR_W-1:0] cb;
  logic c_idx, c_dat;
  assign cb    = strap_alt ? BASE_ALT : BASE_PRI;
  assign c_idx = (io_addr == cb);
  assign c_dat = (io_addr == cb + ADDR_W'(1));

  // R2: opening is always preceded by an enter-key index write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && c_idx && io_wdata == KEY_ENTER));

  // R3: exit key closes the port on the next cycle
  a_r3_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && c_idx && io_wdata == KEY_EXIT) |=> !cfg_open);

  // R9: locked port never strobes the bank and reads idle
  a_r9_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (!rf_wr && !rf_rd && io_rdata == 8'hFF));

  // R5: identification byte
  a_r5_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && c_dat && idx_q == ID_IDX) |-> io_rdata == CHIP_ID);

  // R11: idle read data without a port read
  a_r11_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && (c_idx || c_dat)) |-> io_rdata == 8'hFF);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .BASE_PRI(BASE_PRI), .BASE_ALT(BASE_ALT),
  .CHIP_ID(CHIP_ID), .KEY_ENTER(KEY_ENTER), .KEY_EXIT(KEY_EXIT),
  .ID_IDX(ID_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
  .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .rf_wr(rf_wr), .rf_rd(rf_rd), .cfg_open(cfg_open), .idx_q(idx_q)
);

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_alt = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata, rf_addr, rf_wdata, rf_rdata;
  logic io_hit, rf_wr, rf_rd;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // model state
  bit m_open = 0, m_half = 0;
  logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata = rf_addr ^ 8'h5A;

  sio_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_hit(io_hit), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input bit w, input bit r,
                      input logic [7:0] d, input string tag);
    logic [15:0] base;
    bit is_i, is_d, bsel;
    logic [7:0] e_rd;
    io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
    #1;
    base = strap_alt ? 16'h004E : 16'h002E;
    is_i = (a == base);
    is_d = (a == base + 16'd1);
    bsel = m_open && m_idx >= 8'h30 && m_ldn == 8'h08;
    e_rd = 8'hFF;
    if (r && is_i && m_open) e_rd = m_idx;
    else if (r && is_d && m_open) begin
      if (m_idx >= 8'h30) e_rd = (m_ldn == 8'h08) ? (m_idx ^ 8'h5A) : 8'hFF;
      else if (m_idx == 8'h07) e_rd = m_ldn;
      else if (m_idx == 8'h20) e_rd = 8'h52;
    end
    chk(tag, "io_hit", io_hit, is_i || is_d);
    chk(tag, "io_rdata", io_rdata, e_rd);
    chk(tag, "rf_wr", rf_wr, w && is_d && bsel);
    chk(tag, "rf_rd", rf_rd, r && is_d && bsel);
    if (w && is_d && bsel) begin
      chk(tag, "rf_addr", rf_addr, m_idx);
      chk(tag, "rf_wdata", rf_wdata, d);
    end
    @(posedge clk);
    if (w && is_i) begin
      if (!m_open) begin
        if (d == 8'h87) begin
          if (m_half) begin m_open = 1; m_half = 0; end
          else m_half = 1;
        end else m_half = 0;
      end else if (d == 8'hAA) begin
        m_open = 0; m_half = 0;
      end else m_idx = d;
    end else if (w && is_d && m_open && m_idx == 8'h07) m_ldn = d;
    @(negedge clk);
    io_wr = 0; io_rd = 0;
  endtask

  // shorthands relative to current base
  function automatic logic [15:0] bi();
    return strap_alt ? 16'h004E : 16'h002E;
  endfunction

  task automatic iw(input logic [7:0] d, input string t); step(bi(), 1, 0, d, t); endtask
  task automatic ir(input string t); step(bi(), 0, 1, 8'h00, t); endtask
  task automatic dw(input logic [7:0] d, input string t); step(bi() + 16'd1, 1, 0, d, t); endtask
  task automatic dr(input string t); step(bi() + 16'd1, 0, 1, 8'h00, t); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, locked reads
    ir("R10"); dr("R10");
    // R9: locked data write ignored
    dw(8'h33, "R9"); ir("R9");
    // R2: broken key
    iw(8'h87, "R2"); iw(8'h12, "R2"); iw(8'h87, "R2"); dr("R2");
    iw(8'h00, "R2"); iw(8'h87, "R2"); dw(8'h55, "R2"); iw(8'h87, "R2");
    // R10: pointer reads zero after opening
    ir("R10");
    // R4: pointer load
    iw(8'h07, "R4"); ir("R4");
    // R10/R6: device number defaults to 0, then written
    dr("R10"); dw(8'h05, "R6"); dr("R6");
    // R5: chip ID, write ignored
    iw(8'h20, "R5"); dr("R5"); dw(8'h11, "R5"); dr("R5");
    // R6: other global index
    iw(8'h25, "R6"); dw(8'h44, "R6"); dr("R6");
    // R8: banked with wrong device
    iw(8'h30, "R8"); dr("R8"); dw(8'h66, "R8");
    iw(8'hF5, "R8"); dr("R8");
    // R7: select watchdog bank
    iw(8'h07, "R7"); dw(8'h08, "R7"); dr("R7");
    iw(8'h30, "R7"); dw(8'hA1, "R7"); dr("R7");
    iw(8'hF6, "R7"); dw(8'h3C, "R7"); dr("R7");
    iw(8'h2F, "R7"); dr("R7");
    // R11: read of unrelated address, idle cycle
    step(16'h0060, 0, 1, 8'h00, "R11"); step(16'h002E, 0, 0, 8'h00, "R11");
    // R3: exit
    iw(8'hAA, "R3"); ir("R3"); dr("R3");
    // R9: locked write to device number
    dw(8'h02, "R9"); iw(8'h87, "R3"); dr("R3");
    iw(8'h87, "R3"); iw(8'h07, "R9"); dr("R9");
    // R1: alternate base
    strap_alt = 1'b1;
    step(16'h002E, 0, 1, 8'h00, "R1"); step(16'h002F, 1, 0, 8'h09, "R1");
    ir("R1"); dr("R1"); step(16'h004F, 0, 0, 8'h00, "R1");
    iw(8'hAA, "R1"); ir("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule